// File: doc/BRIEF.md
# Register-Mapped Console Port with Receive FIFO

This block is a small character port placed on a 32-bit system bus. Software writes a single character to a transmit register and the block emits that byte on a byte-wide output stream. Bytes arriving on a byte-wide input stream are stored in an internal receive FIFO. Software reads a register to learn how many received bytes are waiting.

A level interrupt signals waiting data. It is switched on and off by command codes written to a command register, not by a mask bit. After every enable command, disable command, received byte and FIFO drain, the line is the enable flag ANDed with "FIFO not empty".

A separate transfer engine moves bulk data to and from memory. This block only holds the 64-bit buffer address and the 32-bit length the engine uses. When the bulk-write or bulk-read command is written, it gives the engine a one-cycle start pulse and a direction bit. The engine drains the receive FIFO through a pop port.

Top module: `con_port`

## Requirements
- R1: After reset the receive FIFO is empty, interrupts are disabled (`irq` low), `rx_ready` is high, `tx_valid` and `xfer_start` are low, and `xfer_ptr` and `xfer_len` are zero.
- R2: A read (bus_valid=1, bus_write=0) of offset 0x04 returns the receive FIFO occupancy. A read of offset 0x20 returns the constant 1. A read of any other offset, write-only offsets included, returns 0.
- R3: A write to offset 0x00 makes `tx_valid` high for exactly the next cycle, with `tx_data` equal to bits 7:0 of the written word.
- R4: A byte is taken from the receive stream in any cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is low exactly when the FIFO holds DEPTH bytes, and a byte offered while full is not stored. Bytes leave through `eng_pop_data` in arrival order.
- R5: Writing command code 1 (word value 1) to offset 0x08 sets the interrupt enable. From the next cycle `irq` is high if the FIFO is not empty.
- R6: Writing command code 0 to offset 0x08 clears the enable, and `irq` is low from the next cycle. While the enable is clear, receiving bytes leaves `irq` low.
- R7: While enabled, a byte received into an empty FIFO raises `irq` in the following cycle.
- R8: While enabled, `irq` falls in the cycle after the pop that empties the FIFO. `irq` is never high while the FIFO is empty.
- R9: Writes to offsets 0x10, 0x18 and 0x14 set `xfer_ptr[31:0]`, `xfer_ptr[63:32]` and `xfer_len`. Command code 2 pulses `xfer_start` for one cycle with `xfer_read`=0. Code 3 pulses it with `xfer_read`=1. Command words above 3 have no effect.
- R10: A pop while the FIFO is empty leaves the occupancy at 0. A push and a pop in the same cycle leave the occupancy unchanged.
- R11: Only word-aligned offsets are decoded. A write to a misaligned offset such as 0x01 or 0x09 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | FIFO can accept a byte |
| irq | output | 1 | Level interrupt |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_read | output | 1 | Direction of the started transfer (1 = drain FIFO to memory) |
| xfer_ptr | output | 64 | Buffer address |
| xfer_len | output | 32 | Buffer length |
| eng_pop | input | 1 | Engine removes the head byte |
| eng_pop_data | output | 8 | Head byte of the receive FIFO |
| eng_pop_avail | output | 1 | FIFO not empty |

## Verification
Directed sequences try the interrupt with data waiting and with the FIFO empty, in both enable states. This separates a line driven by the enable flag alone from one gated by occupancy. A fill to full followed by a complete drain tests backpressure and arrival order; a wrong full threshold or a pointer wrap error shows up there. Seeded random mixes of pushes, pops, simultaneous push-and-pop and enable/disable commands are compared every step against a bench model of occupancy and `irq`. This exposes occupancy drift and stale interrupt levels that short directed runs would miss.

// File: rtl/con_pkg.sv
package con_pkg;

    localparam int OFF_PUTC    = 'h00;
    localparam int OFF_FILL    = 'h04;
    localparam int OFF_CMD     = 'h08;
    localparam int OFF_PTR_LO  = 'h10;
    localparam int OFF_LEN     = 'h14;
    localparam int OFF_PTR_HI  = 'h18;
    localparam int OFF_VERSION = 'h20;

    typedef enum logic [1:0] {
        CMD_IRQ_OFF = 2'd0,
        CMD_IRQ_ON  = 2'd1,
        CMD_XFER_WR = 2'd2,
        CMD_XFER_RD = 2'd3
    } con_cmd_e;

    typedef struct packed {
        logic put;
        logic cmd;
        logic ptr_lo;
        logic ptr_hi;
        logic len;
        logic rd_fill;
        logic rd_version;
    } con_sel_t;

endpackage

// File: rtl/con_addr_decode.sv
module con_addr_decode
    import con_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output con_sel_t          sel
);
    logic wr;
    logic rd;

    always_comb begin
        wr = bus_valid && bus_write;
        rd = bus_valid && !bus_write;
        sel.put        = wr && (bus_addr == ADDR_W'(OFF_PUTC));
        sel.cmd        = wr && (bus_addr == ADDR_W'(OFF_CMD));
        sel.ptr_lo     = wr && (bus_addr == ADDR_W'(OFF_PTR_LO));
        sel.ptr_hi     = wr && (bus_addr == ADDR_W'(OFF_PTR_HI));
        sel.len        = wr && (bus_addr == ADDR_W'(OFF_LEN));
        sel.rd_fill    = rd && (bus_addr == ADDR_W'(OFF_FILL));
        sel.rd_version = rd && (bus_addr == ADDR_W'(OFF_VERSION));
    end

endmodule

// File: rtl/con_rx_fifo.sv
module con_rx_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [W-1:0]               in_data,
    output logic                       in_ready,
    input  logic                       out_pop,
    output logic [W-1:0]               out_data,
    output logic                       out_avail,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic [$clog2(DEPTH+1)-1:0] cnt_next
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic push, pop;

    always_comb begin
        push = in_valid && (st_q.cnt != CNT_W'(DEPTH));
        pop  = out_pop && (st_q.cnt != '0);
        st_d = st_q;
        if (push) st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (pop)  st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr] <= in_data;
    end

    assign in_ready  = (st_q.cnt != CNT_W'(DEPTH));
    assign out_data  = mem_q[st_q.rd];
    assign out_avail = (st_q.cnt != '0);
    assign cnt       = st_q.cnt;
    assign cnt_next  = st_d.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R4
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && in_valid && !out_pop) |=> (st_q.cnt == CNT_W'(DEPTH))); // R4
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pop && !out_avail && !in_valid) |=> (st_q.cnt == '0)); // R10
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && out_pop && out_avail) |=> $stable(st_q.cnt)); // R10

endmodule

// File: rtl/con_port.sv
module con_port
    import con_pkg::*;
#(
    parameter int          ADDR_W  = 6,
    parameter int          DEPTH   = 128,
    parameter logic [31:0] VERSION = 32'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              irq,
    output logic              xfer_start,
    output logic              xfer_read,
    output logic [63:0]       xfer_ptr,
    output logic [31:0]       xfer_len,
    input  logic              eng_pop,
    output logic [7:0]        eng_pop_data,
    output logic              eng_pop_avail
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [63:0] ptr;
        logic [31:0] len;
        logic        en;
        logic        irq;
        logic        tx_valid;
        logic [7:0]  tx_data;
        logic        xstart;
        logic        xread;
    } port_st_t;

    port_st_t st_d, st_q;
    con_sel_t sel;
    logic [CNT_W-1:0] fill_cnt, fill_next;
    logic cmd_ok;

    con_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .sel       (sel)
    );

    con_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_data   (rx_data),
        .in_ready  (rx_ready),
        .out_pop   (eng_pop),
        .out_data  (eng_pop_data),
        .out_avail (eng_pop_avail),
        .cnt       (fill_cnt),
        .cnt_next  (fill_next)
    );

    always_comb begin
        cmd_ok        = sel.cmd && (bus_wdata[31:2] == '0);
        st_d          = st_q;
        st_d.tx_valid = 1'b0;
        st_d.xstart   = 1'b0;
        if (sel.put) begin
            st_d.tx_valid = 1'b1;
            st_d.tx_data  = bus_wdata[7:0];
        end
        if (sel.ptr_lo) st_d.ptr[31:0]  = bus_wdata;
        if (sel.ptr_hi) st_d.ptr[63:32] = bus_wdata;
        if (sel.len)    st_d.len        = bus_wdata;
        if (cmd_ok) begin
            case (con_cmd_e'(bus_wdata[1:0]))
                CMD_IRQ_OFF: st_d.en = 1'b0;
                CMD_IRQ_ON:  st_d.en = 1'b1;
                CMD_XFER_WR: begin st_d.xstart = 1'b1; st_d.xread = 1'b0; end
                CMD_XFER_RD: begin st_d.xstart = 1'b1; st_d.xread = 1'b1; end
                default: ;
            endcase
        end
        st_d.irq = st_d.en && (fill_next != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel.rd_fill)    bus_rdata = 32'(fill_cnt);
        if (sel.rd_version) bus_rdata = VERSION;
    end

    assign tx_valid   = st_q.tx_valid;
    assign tx_data    = st_q.tx_data;
    assign irq        = st_q.irq;
    assign xfer_start = st_q.xstart;
    assign xfer_read  = st_q.xread;
    assign xfer_ptr   = st_q.ptr;
    assign xfer_len   = st_q.len;

    AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sel.put |=> (tx_valid && tx_data == $past(bus_wdata[7:0]))); // R3
    AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.cmd && bus_wdata == 32'd1 && fill_next != '0) |=> irq); // R5
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.cmd && bus_wdata == 32'd0) |=> !irq); // R6
    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> eng_pop_avail); // R8
    AST_XFER_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> $past(sel.cmd && bus_wdata[31:1] == 31'd1)); // R9
    AST_BAD_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.cmd && bus_wdata > 32'd3) |=> !xfer_start); // R9

endmodule

// File: tb/tb_con_port.sv
module tb_con_port;
    localparam int DEPTH = 128;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_valid = 0, bus_write = 0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        rx_valid = 0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, irq, xfer_start, xfer_read;
    logic [63:0] xfer_ptr;
    logic [31:0] xfer_len;
    logic        eng_pop = 0;
    logic [7:0]  eng_pop_data;
    logic        eng_pop_avail;

    con_port dut (.*);

    always #5 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    logic [7:0] mq[$];
    bit m_en = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_irq();
        return m_en && (mq.size() != 0);
    endfunction

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 0; bus_write = 0;
        if (a == 6'h08 && d == 0) m_en = 0;
        if (a == 6'h08 && d == 1) m_en = 1;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 0;
    endtask

    // one cycle of receive push and/or engine pop, model updated
    task automatic step(input bit push, input logic [7:0] b, input bit pop, input string req);
        bit acc, pp;
        @(negedge clk);
        rx_valid = push; rx_data = b; eng_pop = pop;
        #1;
        chk(rx_ready == (mq.size() < DEPTH), req, rx_ready, mq.size() < DEPTH);
        acc = push && rx_ready;
        pp  = pop && (mq.size() != 0);
        if (pp) chk(eng_pop_data == mq[0], req, eng_pop_data, mq[0]);
        @(posedge clk); #1;
        rx_valid = 0; eng_pop = 0;
        if (pp) void'(mq.pop_front());
        if (acc) mq.push_back(b);
    endtask

    task automatic idle();
        @(negedge clk); @(posedge clk); #1;
    endtask

    task automatic chk_fill(input string req);
        logic [31:0] d;
        bus_rd(6'h04, d);
        chk(d == mq.size(), req, d, mq.size());
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk(irq == 0 && rx_ready == 1 && tx_valid == 0 && xfer_start == 0, "R1", {irq, rx_ready, tx_valid, xfer_start}, 4'b0100);
        chk(xfer_ptr == 0 && xfer_len == 0, "R1", xfer_ptr, 0);
        chk_fill("R1");
        // R2 version and unreadable offsets
        bus_rd(6'h20, d); chk(d == 1, "R2", d, 1);
        bus_rd(6'h08, d); chk(d == 0, "R2", d, 0);
        bus_rd(6'h00, d); chk(d == 0, "R2", d, 0);
        bus_rd(6'h14, d); chk(d == 0, "R2", d, 0);
        // R3 put-char
        bus_wr(6'h00, 32'h1A5);
        chk(tx_valid && tx_data == 8'hA5, "R3", {tx_valid, tx_data}, 9'h1A5);
        idle();
        chk(tx_valid == 0, "R3", tx_valid, 0);
        // R11 misaligned
        bus_wr(6'h01, 32'h55);
        chk(tx_valid == 0, "R11", tx_valid, 0);
        // R6 receive while disabled
        step(1, 8'h11, 0, "R6");
        chk(irq == 0, "R6", irq, 0);
        chk_fill("R2");
        bus_wr(6'h09, 32'h1);
        m_en = 0;
        idle();
        chk(irq == 0, "R11", irq, 0);
        // R5 enable with data
        bus_wr(6'h08, 32'h1);
        chk(irq == 1, "R5", irq, 1);
        bus_wr(6'h08, 32'h0);
        chk(irq == 0, "R6", irq, 0);
        bus_wr(6'h08, 32'h5);
        chk(irq == 0 && xfer_start == 0, "R9", {irq, xfer_start}, 0);
        // R9 pointer, length, transfer commands
        bus_wr(6'h10, 32'hDEAD_BEEF);
        bus_wr(6'h18, 32'h0123_4567);
        bus_wr(6'h14, 32'd300);
        chk(xfer_ptr == 64'h0123_4567_DEAD_BEEF, "R9", xfer_ptr, 64'h0123_4567_DEAD_BEEF);
        chk(xfer_len == 300, "R9", xfer_len, 300);
        bus_wr(6'h08, 32'h2);
        chk(xfer_start && !xfer_read, "R9", {xfer_start, xfer_read}, 2'b10);
        bus_wr(6'h08, 32'h3);
        chk(xfer_start && xfer_read, "R9", {xfer_start, xfer_read}, 2'b11);
        idle();
        chk(!xfer_start && xfer_ptr == 64'h0123_4567_DEAD_BEEF, "R9", xfer_start, 0);
        // R8 drain while enabled
        bus_wr(6'h08, 32'h1);
        step(1, 8'h22, 0, "R4");
        chk(irq == 1, "R7", irq, 1);
        step(0, 0, 1, "R4");
        chk(irq == 1, "R8", irq, 1);
        step(0, 0, 1, "R4");
        chk(irq == 0, "R8", irq, 0);
        // R7 receive into empty while enabled
        step(1, 8'h33, 0, "R7");
        chk(irq == 1, "R7", irq, 1);
        step(0, 0, 1, "R7");
        chk(irq == 0, "R8", irq, 0);
        // R10 pop on empty
        step(0, 0, 1, "R10");
        chk_fill("R10");
        // R4 fill to full, overflow attempt, drain order
        for (int i = 0; i < DEPTH; i++) step(1, 8'(i * 7 + 3), 0, "R4");
        chk(rx_ready == 0, "R4", rx_ready, 0);
        step(1, 8'hEE, 0, "R4");
        chk_fill("R4");
        step(1, 8'hEF, 1, "R10");
        chk_fill("R10");
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, "R4");
        chk_fill("R4");
        chk(irq == 0, "R8", irq, 0);
        // random mix against model
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4)       step(1, 8'($urandom), 0, "R4");
            else if (op < 6)  step(0, 0, 1, "R4");
            else if (op == 6) step(1, 8'($urandom), 1, "R10");
            else if (op == 7) bus_wr(6'h08, 32'($urandom_range(0, 1)));
            else              chk_fill("R2");
            chk(irq == exp_irq(), "R5", irq, exp_irq());
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule